// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of debug triggers and checks each access of a hart against them. Every access arrives as an operation kind (instruction fetch, store or load), an address, a data word, the current privilege level, the current register width (32 or 64 bits) and a flag that is set while the hart is halted in debug mode. The block answers in the same cycle with a valid bit and the index of the trigger that fired.

Each trigger holds a control word and a compare value. Both are loaded through one write port, one word per clock edge. The control word enables the trigger per operation and per privilege level, and picks whether the address or the data word is compared. It also selects one of six compare rules and can link the trigger to the one after it. Linked triggers form a chain, and a chain reports only when all of its members agree.

Top module: `dbg_trig_match`

## Requirements
- R1: After reset every control word is zero, so `hit_o` stays 0 for any access until a trigger is configured.
- R2: While `dbg_halt_i` is 1, `hit_o` is 0 whatever the configuration and access.
- R3: A trigger can match only if its enable bit for the current operation is set and its enable bit for the current privilege is set. Operation codes: 0 fetch (control bit 0), 1 store (bit 1), 2 load (bit 2), 3 none (never matches). Privilege codes: 0 user (bit 3), 1 supervisor (bit 4), 3 machine (bit 5), 2 never matches.
- R4: Control bit 6 chooses the compared operand: `data_i` when set, `addr_i` when clear.
- R5: When `xlen64_i` is 0, the operand is cut to its low 32 bits before any compare. The compare value is not cut.
- R6: Control bits 9:7 hold the compare rule. Rule 0 fires on equality. Rule 2 fires when the operand is greater than or equal to the compare value, unsigned. Rule 3 fires when the operand is strictly below it, unsigned.
- R7: Rule 1 (aligned range): let n be the number of consecutive ones in the compare value starting from bit 0. The operand fires when all bits at position n and above equal those of the compare value.
- R8: Let h be 32 when `xlen64_i` is 1 and 16 otherwise, and let the mask be the compare value shifted right by h. Rule 4 fires when (operand AND mask) equals (compare AND mask). Rule 5 fires when ((operand shifted right by h) AND mask) equals (compare AND mask).
- R9: Rules 6 and 7 never fire.
- R10: When several independent triggers match, `hit_idx_o` holds the lowest index among them.
- R11: Control bit 10 links a trigger to the next one. A chain is a run of linked triggers closed by the first trigger whose link bit is clear. The chain fires only if every member matches, and it reports the index of the closing trigger. A chain with a failing member reports nothing, and evaluation goes on after the closing trigger.
- R12: A run of linked triggers that reaches the last trigger with its link bit still set is never closed and never reports.
- R13: A write with `cfg_sel_i`=0 loads bits 10:0 of `cfg_wdata_i` into the control word of trigger `cfg_idx_i`. A write with `cfg_sel_i`=1 loads the whole word into its compare value. The new setting acts on the outputs only after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Trigger chosen by the write |
| cfg_sel_i | input | 1 | 0 writes the control word, 1 writes the compare value |
| cfg_wdata_i | input | 64 | Write data |
| op_i | input | 2 | Access kind: 0 fetch, 1 store, 2 load, 3 none |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| xlen64_i | input | 1 | 1 for 64-bit register width, 0 for 32-bit |
| dbg_halt_i | input | 1 | Hart halted in debug mode |
| addr_i | input | 64 | Access address |
| data_i | input | 64 | Access data |
| hit_o | output | 1 | A trigger or chain fired |
| hit_idx_o | output | 2 | Index of the reporting trigger |

## Verification
The bench sweeps every compare rule over compare values with several trailing-one counts and over operands one bit away from the boundary, in both register widths and with both operand selections. A bad aligned-range mask would show up at the all-ones and the zero compare values, and a shift by the wrong half-width would break the masked rules in 32-bit mode. All 64 enable combinations are tried against all operation and privilege codes, which catches a swapped enable bit. All 256 pairs of link pattern and match pattern are run, which exposes a chain that reports its first member, skips a failing member, or reports with the last link bit open. Separate checks look at the cycle in which a configuration write takes effect and confirm that debug halt suppresses a match.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'd0,
        OP_STORE = 2'd1,
        OP_LOAD  = 2'd2,
        OP_NONE  = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_SUPER = 2'd1,
        PL_RSV   = 2'd2,
        PL_MACH  = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        RULE_EQ    = 3'd0,
        RULE_ALIGN = 3'd1,
        RULE_GE    = 3'd2,
        RULE_LT    = 3'd3,
        RULE_MLO   = 3'd4,
        RULE_MHI   = 3'd5
    } cmp_rule_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic       link;      // 10
        logic [2:0] rule;      // 9:7
        logic       use_data;  // 6
        logic       en_mach;   // 5
        logic       en_super;  // 4
        logic       en_user;   // 3
        logic       en_load;   // 2
        logic       en_store;  // 1
        logic       en_exec;   // 0
    } trig_ctl_t;

    localparam int unsigned CTL_W = $bits(trig_ctl_t);

    function automatic logic op_allowed(trig_ctl_t c, logic [1:0] op);
        case (op)
            OP_EXEC:  return c.en_exec;
            OP_STORE: return c.en_store;
            OP_LOAD:  return c.en_load;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic priv_allowed(trig_ctl_t c, logic [1:0] pv);
        case (pv)
            PL_USER:  return c.en_user;
            PL_SUPER: return c.en_super;
            PL_MACH:  return c.en_mach;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_pkg::*;
#(
    parameter int unsigned NTRIG = 4,
    parameter int unsigned XW    = 64,
    localparam int unsigned IW   = $clog2(NTRIG)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IW-1:0]                  idx,
    input  logic                           sel_cmp,
    input  logic [XW-1:0]                  wdata,
    output trig_ctl_t [NTRIG-1:0]          ctl_q,
    output logic      [NTRIG-1:0][XW-1:0]  cmp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmp_q <= '0;
        end else if (we) begin
            if (sel_cmp) begin
                cmp_q[idx] <= wdata;
            end else begin
                ctl_q[idx] <= trig_ctl_t'(wdata[CTL_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int unsigned XW = 64
) (
    input  trig_ctl_t          ctl,
    input  logic [XW-1:0]      cmpv,
    input  logic [1:0]         op,
    input  logic [1:0]         priv,
    input  logic               wide,
    input  logic [XW-1:0]      addr,
    input  logic [XW-1:0]      data,
    output logic               hit
);

    localparam int unsigned HW = XW / 2;
    localparam int unsigned SW = $clog2(XW);
    localparam logic [SW-1:0] SH_WIDE   = SW'(HW);
    localparam logic [SW-1:0] SH_NARROW = SW'(HW / 2);
    localparam logic [XW-1:0] LOW_HALF  = {{HW{1'b0}}, {HW{1'b1}}};

    logic [XW-1:0] operand;
    logic [XW-1:0] value;
    logic [SW-1:0] half_sh;
    logic [XW-1:0] half_mask;
    logic [XW-1:0] value_hi;
    logic [XW-1:0] tail_ones;
    logic          rule_ok;

    always_comb begin
        operand   = ctl.use_data ? data : addr;
        value     = wide ? operand : (operand & LOW_HALF);
        half_sh   = wide ? SH_WIDE : SH_NARROW;
        half_mask = cmpv >> half_sh;
        value_hi  = value >> half_sh;
        // ones below the lowest zero of the compare value
        tail_ones = cmpv & ~(cmpv + {{(XW-1){1'b0}}, 1'b1});

        case (ctl.rule)
            RULE_EQ:    rule_ok = (value == cmpv);
            RULE_ALIGN: rule_ok = ((value & ~tail_ones) == (cmpv & ~tail_ones));
            RULE_GE:    rule_ok = (value >= cmpv);
            RULE_LT:    rule_ok = (value < cmpv);
            RULE_MLO:   rule_ok = ((value & half_mask) == (cmpv & half_mask));
            RULE_MHI:   rule_ok = ((value_hi & half_mask) == (cmpv & half_mask));
            default:    rule_ok = 1'b0;
        endcase

        hit = op_allowed(ctl, op) & priv_allowed(ctl, priv) & rule_ok;
    end

endmodule

// File: rtl/trig_chain_resolve.sv
module trig_chain_resolve #(
    parameter int unsigned NTRIG = 4,
    localparam int unsigned IW   = $clog2(NTRIG)
) (
    input  logic [NTRIG-1:0] match_vec,
    input  logic [NTRIG-1:0] link_vec,
    input  logic             quiet,
    output logic             fired,
    output logic [IW-1:0]    fired_idx
);

    logic run_ok;
    logic step_ok;
    logic found;

    always_comb begin
        found     = 1'b0;
        fired_idx = '0;
        run_ok    = 1'b1;
        step_ok   = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            step_ok = run_ok & match_vec[i];
            if (!link_vec[i]) begin
                if (step_ok && !found) begin
                    found     = 1'b1;
                    fired_idx = IW'(i);
                end
                run_ok = 1'b1;
            end else begin
                run_ok = step_ok;
            end
        end
        fired = found & ~quiet;
    end

endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
    import trig_pkg::*;
#(
    parameter int unsigned NTRIG = 4,
    parameter int unsigned XW    = 64,
    localparam int unsigned IW   = $clog2(NTRIG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we_i,
    input  logic [IW-1:0]   cfg_idx_i,
    input  logic            cfg_sel_i,
    input  logic [XW-1:0]   cfg_wdata_i,
    input  logic [1:0]      op_i,
    input  logic [1:0]      priv_i,
    input  logic            xlen64_i,
    input  logic            dbg_halt_i,
    input  logic [XW-1:0]   addr_i,
    input  logic [XW-1:0]   data_i,
    output logic            hit_o,
    output logic [IW-1:0]   hit_idx_o
);

    trig_ctl_t [NTRIG-1:0]         ctl_q;
    logic      [NTRIG-1:0][XW-1:0] cmp_q;
    logic      [NTRIG-1:0]         match_vec;
    logic      [NTRIG-1:0]         link_vec;

    trig_cfg_bank #(.NTRIG(NTRIG), .XW(XW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we_i),
        .idx     (cfg_idx_i),
        .sel_cmp (cfg_sel_i),
        .wdata   (cfg_wdata_i),
        .ctl_q   (ctl_q),
        .cmp_q   (cmp_q)
    );

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        assign link_vec[g] = ctl_q[g].link;
        trig_cmp #(.XW(XW)) u_cmp (
            .ctl  (ctl_q[g]),
            .cmpv (cmp_q[g]),
            .op   (op_i),
            .priv (priv_i),
            .wide (xlen64_i),
            .addr (addr_i),
            .data (data_i),
            .hit  (match_vec[g])
        );
    end

    trig_chain_resolve #(.NTRIG(NTRIG)) u_resolve (
        .match_vec (match_vec),
        .link_vec  (link_vec),
        .quiet     (dbg_halt_i),
        .fired     (hit_o),
        .fired_idx (hit_idx_o)
    );

endmodule

// File: rtl/dbg_trig_match_chk.sv
module dbg_trig_match_chk
    import trig_pkg::*;
#(
    parameter int unsigned NTRIG = 4,
    localparam int unsigned IW   = $clog2(NTRIG)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            op_i,
    input logic [1:0]            priv_i,
    input logic                  dbg_halt_i,
    input logic                  hit_o,
    input logic [IW-1:0]         hit_idx_o,
    input trig_ctl_t [NTRIG-1:0] ctl_q
);

    // R1: the first cycle out of reset still sees a cleared bank
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !hit_o);

    // R2
    a_r2_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        dbg_halt_i |-> !hit_o);

    // R3
    a_r3_op_none_quiet: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NONE) |-> !hit_o);

    // R3
    a_r3_priv_rsv_quiet: assert property (@(posedge clk) disable iff (rst)
        (priv_i == PL_RSV) |-> !hit_o);

    // R3
    a_r3_exec_enabled: assert property (@(posedge clk) disable iff (rst)
        (hit_o && op_i == OP_EXEC) |-> ctl_q[hit_idx_o].en_exec);

    // R11, R12: a reported trigger always closes its chain
    a_r11_reporter_unlinked: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> !ctl_q[hit_idx_o].link);

endmodule

bind dbg_trig_match dbg_trig_match_chk #(.NTRIG(NTRIG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .priv_i     (priv_i),
    .dbg_halt_i (dbg_halt_i),
    .hit_o      (hit_o),
    .hit_idx_o  (hit_idx_o),
    .ctl_q      (ctl_q)
);

// File: tb/test_dbg_trig_match.sv
`timescale 1ns/1ps
module test_dbg_trig_match;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_idx_i = '0;
    logic        cfg_sel_i = 1'b0;
    logic [63:0] cfg_wdata_i = '0;
    logic [1:0]  op_i = 2'd0;
    logic [1:0]  priv_i = 2'd3;
    logic        xlen64_i = 1'b1;
    logic        dbg_halt_i = 1'b0;
    logic [63:0] addr_i = '0;
    logic [63:0] data_i = '0;
    logic        hit_o;
    logic [1:0]  hit_idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [10:0] m_ctl [4];
    logic [63:0] m_cmp [4];

    always #10 clk = ~clk;

    dbg_trig_match i_dbg_trig_match (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .op_i(op_i),
        .priv_i(priv_i), .xlen64_i(xlen64_i), .dbg_halt_i(dbg_halt_i),
        .addr_i(addr_i), .data_i(data_i), .hit_o(hit_o), .hit_idx_o(hit_idx_o)
    );

    function automatic logic [63:0] ctl_word(bit link, int rule, bit use_d, logic [5:0] en);
        return {53'b0, link, 3'(rule), use_d, en};
    endfunction

    function automatic bit m_match(int i, logic [1:0] op, logic [63:0] a, logic [63:0] d,
                                   logic [1:0] pv, bit x64);
        logic [10:0] c = m_ctl[i];
        logic [63:0] t = m_cmp[i];
        logic [63:0] v;
        logic [63:0] mk;
        int h;
        int n;
        if (op == 2'd3 || !c[op]) return 0;
        case (pv)
            2'd0: if (!c[3]) return 0;
            2'd1: if (!c[4]) return 0;
            2'd3: if (!c[5]) return 0;
            default: return 0;
        endcase
        v = c[6] ? d : a;
        if (!x64) v = {32'b0, v[31:0]};
        h = x64 ? 32 : 16;
        case (c[9:7])
            3'd0: return v == t;
            3'd1: begin
                n = 0;
                while (n < 64 && t[n]) n++;
                for (int b = n; b < 64; b++) if (v[b] != t[b]) return 0;
                return 1;
            end
            3'd2: return v >= t;
            3'd3: return v < t;
            3'd4: begin mk = t >> h; return (v & mk) == (t & mk); end
            3'd5: begin mk = t >> h; return ((v >> h) & mk) == (t & mk); end
            default: return 0;
        endcase
    endfunction

    task automatic model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] d,
                         input logic [1:0] pv, input bit x64, input bit halt,
                         output bit ev, output logic [1:0] ei);
        int i = 0;
        ev = 0;
        ei = 0;
        if (halt) return;
        while (i < 4) begin
            int e = i;
            bit all = 1;
            while (e < 4 && m_ctl[e][10]) e++;
            if (e == 4) return;
            for (int k = i; k <= e; k++) all &= m_match(k, op, a, d, pv, x64);
            if (all) begin ev = 1; ei = 2'(e); return; end
            i = e + 1;
        end
    endtask

    task automatic wr(input int idx, input bit sel, input logic [63:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = 2'(idx); cfg_sel_i = sel; cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
        if (sel) m_cmp[idx] = v; else m_ctl[idx] = v[10:0];
    endtask

    task automatic probe(input logic [1:0] op, input logic [63:0] a, input logic [63:0] d,
                         input logic [1:0] pv, input bit x64, input bit halt, input string tag);
        bit ev;
        logic [1:0] ei;
        @(negedge clk);
        op_i = op; addr_i = a; data_i = d; priv_i = pv; xlen64_i = x64; dbg_halt_i = halt;
        #5;
        model(op, a, d, pv, x64, halt, ev, ei);
        checks++;
        if (hit_o !== ev || (ev && hit_idx_o !== ei)) begin
            errors++;
            $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, hit_o, hit_idx_o, ev, ei);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            wr(i, 0, 64'd0);
            wr(i, 1, 64'd0);
        end
    endtask

    function automatic string rule_tag(int r);
        case (r)
            1: return "R7 align";
            4, 5: return "R8 masked";
            6, 7: return "R9 reserved rule";
            default: return "R6 compare";
        endcase
    endfunction

    function automatic logic [63:0] pick_t(int k);
        case (k)
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h0000_0000_8000_00FF;
            3: return 64'h00FF_0000_1234_5678;
            4: return 64'hF0F0_00FF_0000_0F0F;
            default: return 64'h0000_FFFF_0000_0007;
        endcase
    endfunction

    function automatic logic [63:0] pick_v(logic [63:0] t, int k);
        case (k)
            0: return t;
            1: return t + 1;
            2: return t - 1;
            3: return ~t;
            4: return t ^ 64'hFFFF_FFFF_0000_0000;
            5: return t ^ 64'h1;
            6: return t ^ 64'h8;
            7: return t ^ 64'h200;
            8: return t ^ 64'h10_0000;
            9: return t ^ 64'h100_0000_0000;
            default: return t ^ 64'h8000_0000_0000_0000;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) begin m_ctl[i] = '0; m_cmp[i] = '0; end
        // R1: in and just out of reset nothing fires
        repeat (3) @(negedge clk);
        probe(2'd0, 64'h0, 64'h0, 2'd3, 1'b1, 1'b0, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        probe(2'd0, 64'h0, 64'h0, 2'd3, 1'b1, 1'b0, "R1 after reset");
        probe(2'd2, 64'h0, 64'h0, 2'd0, 1'b0, 1'b0, "R1 after reset load");

        // R6 R7 R8 R9: rule sweep on trigger 0
        for (int r = 0; r < 8; r++) begin
            for (int tk = 0; tk < 6; tk++) begin
                wr(0, 1, pick_t(tk));
                for (int sd = 0; sd < 2; sd++) begin
                    wr(0, 0, ctl_word(0, r, sd[0], 6'h3F));
                    for (int x = 0; x < 2; x++)
                        for (int vk = 0; vk < 11; vk++) begin
                            logic [63:0] v = pick_v(pick_t(tk), vk);
                            if (sd == 1) probe(2'd2, ~v, v, 2'd3, x[0], 1'b0, rule_tag(r));
                            else         probe(2'd2, v, ~v, 2'd3, x[0], 1'b0, rule_tag(r));
                        end
                end
            end
        end

        // R3: every enable combination against every operation and privilege code
        wr(0, 1, 64'h40);
        for (int en = 0; en < 64; en++) begin
            wr(0, 0, ctl_word(0, 0, 0, 6'(en)));
            for (int op = 0; op < 4; op++)
                for (int pv = 0; pv < 4; pv++)
                    probe(2'(op), 64'h40, 64'h0, 2'(pv), 1'b1, 1'b0, "R3 enables");
        end

        // R4: operand select
        wr(0, 0, ctl_word(0, 0, 1, 6'h3F));
        probe(2'd1, 64'h40, 64'h41, 2'd3, 1'b1, 1'b0, "R4 data selected, addr equal");
        probe(2'd1, 64'h41, 64'h40, 2'd3, 1'b1, 1'b0, "R4 data selected, data equal");
        wr(0, 0, ctl_word(0, 0, 0, 6'h3F));
        probe(2'd1, 64'h41, 64'h40, 2'd3, 1'b1, 1'b0, "R4 addr selected, data equal");

        // R5: upper bits dropped only in 32-bit mode
        wr(0, 1, 64'h1234);
        probe(2'd0, 64'hFFFF_FFFF_0000_1234, 64'h0, 2'd1, 1'b0, 1'b0, "R5 narrow truncation");
        probe(2'd0, 64'hFFFF_FFFF_0000_1234, 64'h0, 2'd1, 1'b1, 1'b0, "R5 wide no truncation");

        // R2: debug halt silences a match
        probe(2'd0, 64'h1234, 64'h0, 2'd3, 1'b1, 1'b1, "R2 halted");
        probe(2'd0, 64'h1234, 64'h0, 2'd3, 1'b1, 1'b0, "R2 released");

        // R10: lowest index among independent matches
        for (int i = 0; i < 4; i++) begin
            wr(i, 0, ctl_word(0, 0, 0, 6'h3F));
            wr(i, 1, (i % 2 == 1) ? 64'h77 : 64'h78);
        end
        probe(2'd2, 64'h77, 64'h0, 2'd0, 1'b1, 1'b0, "R10 lowest of 1 and 3");
        for (int i = 0; i < 4; i++) wr(i, 1, 64'h77);
        probe(2'd2, 64'h77, 64'h0, 2'd0, 1'b1, 1'b0, "R10 all match");
        probe(2'd2, 64'h77, 64'h0, 2'd0, 1'b1, 1'b1, "R2 halted with all matching");

        // R11 R12: every link pattern against every match pattern
        for (int cp = 0; cp < 16; cp++) begin
            for (int i = 0; i < 4; i++) wr(i, 0, ctl_word(cp[i], 0, 0, 6'h3F));
            for (int mp = 0; mp < 16; mp++) begin
                for (int i = 0; i < 4; i++) wr(i, 1, mp[i] ? 64'h55 : 64'h56);
                probe(2'd0, 64'h55, 64'h0, 2'd3, 1'b1, 1'b0,
                      cp[3] ? "R12 open chain at end" : "R11 chain");
            end
        end

        // R13: a write acts only after its clock edge
        clear_all();
        wr(2, 0, ctl_word(0, 0, 0, 6'h3F));
        wr(2, 1, 64'hABC);
        @(negedge clk);
        op_i = 2'd0; addr_i = 64'hABC; priv_i = 2'd3; xlen64_i = 1'b1; dbg_halt_i = 1'b0;
        cfg_we_i = 1'b1; cfg_idx_i = 2'd2; cfg_sel_i = 1'b1; cfg_wdata_i = 64'hABD;
        #5;
        checks++;
        if (hit_o !== 1'b1 || hit_idx_o !== 2'd2) begin
            errors++;
            $display("FAIL R13 before edge: hit=%0b idx=%0d expected hit=1 idx=2", hit_o, hit_idx_o);
        end
        @(negedge clk);
        cfg_we_i = 1'b0;
        m_cmp[2] = 64'hABD;
        #5;
        checks++;
        if (hit_o !== 1'b0) begin
            errors++;
            $display("FAIL R13 after edge: hit=%0b expected hit=0", hit_o);
        end
        // control write leaves the compare value alone
        wr(2, 0, ctl_word(0, 2, 0, 6'h3F));
        probe(2'd0, 64'hABD, 64'h0, 2'd3, 1'b1, 1'b0, "R13 control write keeps compare");
        probe(2'd0, 64'hABC, 64'h0, 2'd3, 1'b1, 1'b0, "R13 control write keeps compare below");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: finished=0 expected finished=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule